// File: doc/BRIEF.md
# GPIO Port Register File

This block holds the software-visible data, direction and pull-resistor state for a general-purpose I/O unit of up to 50 pins, reached through 16-bit registers on a request/response port. Pins 0 to 31 are bidirectional: each has a direction bit and an output latch, and a read of its data register shows the driven value when the pin is an output and the synchronised pad level when it is an input. Pins 32 and up are driven from two output-data registers and are output-only unless an enable reaches them.

Two build parameters set the variant. `NUM_PINS` selects 36, 48 or 50 pins. `SEP_OE` selects where the enables for pins 32 and up live: either in a dedicated enable register pair, one bit per pin, or packed into spare bits 8 and 9 of the high output-data register. In the packed form only pins 48 and 49 can be disabled and pins 32 to 47 are always driven. Only the 50-pin variant has pull control, which uses one register to switch the pull on and a second to choose its direction.

Requests use a valid/ready handshake and every accepted request returns exactly one response one cycle later. A response that is not taken (`rsp_ready` low) is held unchanged and blocks the next request, so back-pressure from the response side propagates to `req_ready` in the same cycle. Software that turns a pin into an output should write the data value first and the direction bit second, so the pad drives the intended level from its first output cycle.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset every direction, output-data, enable and pull bit is 0: pins 0–31 are inputs with no pull, and in packed-enable builds pins 32–47 drive 0 while pins 48–49 are disabled.
- R2: Offsets 0x000 and 0x002 hold the direction bits of pins 0–15 and 16–31 (bit n of a register maps to pin n of its range); a 1 drives `pad_oe` high for that pin and the register reads back what was written.
- R3: Offsets 0x004 and 0x006 write the output latches of pins 0–15 and 16–31; a read returns the latch bit for output pins and the pad level after `SYNC_STAGES` clock edges for input pins.
- R4: Offset 0x01C holds output data for pins 32–47 and offset 0x01E bits 0–1 hold pins 48–49; they drive `pad_out` and read back what was written.
- R5: With `SEP_OE`=0, bits 8 and 9 of offset 0x01E enable pins 48 and 49, and pins 32–47 have `pad_oe` fixed at 1.
- R6: With `SEP_OE`=1, offset 0x020 (pins 32–47) and offset 0x022 (pins 48–49) hold one enable bit per pin indexed from pin 32, and bits 8–9 of offset 0x01E do not exist.
- R7: In 50-pin builds offset 0x1E0 bits 0–14 switch the pull of pins 0–14 on (`pull_en`) and offset 0x1E2 bits 0–14 choose up (1) or down (0) on `pull_up`; bit 15 of both is ignored.
- R8: Writes to unmapped offsets, to registers the variant lacks, or to bits above the pin count change nothing and those locations read as 0.
- R9: A request is taken on a clock edge where `req_valid` and `req_ready` are high; its response is valid after that edge, carries read data (0 for a write), and stays unchanged while `rsp_ready` is low, during which `req_ready` is low.
- R10: A pin made an output after its data bit was written drives that data value in the first cycle its `pad_oe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 9 | Byte offset of the register |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer can take it |
| rsp_rdata | output | 16 | Read data, 0 for writes |
| pad_in | input | 32 | Pad levels of pins 0–31 |
| pad_out | output | NUM_PINS | Output value of every pin |
| pad_oe | output | NUM_PINS | Output enable of every pin |
| pull_en | output | 15 | Pull resistor on, pins 0–14 |
| pull_up | output | 15 | Pull direction, 1 = up |

## Verification
The bench builds two copies side by side on one request bus: a 50-pin build with packed enables and a 36-pin build with the separate enable register. The first exercises pull control, the high output-data register and the packed enable bits; the second exercises the enable register, a partly populated low output register and the reads-as-zero behaviour of every register the small variant lacks. The 48-pin build is not instantiated, though its decode differs from the others only in register existence.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int ADDR_W    = 9;
  localparam int DATA_W    = 16;
  localparam int BIDIR_N   = 32;
  localparam int PULL_N    = 15;

  localparam logic [ADDR_W-1:0] OFS_DIR_LO   = 9'h000;
  localparam logic [ADDR_W-1:0] OFS_DIR_HI   = 9'h002;
  localparam logic [ADDR_W-1:0] OFS_PIN_LO   = 9'h004;
  localparam logic [ADDR_W-1:0] OFS_PIN_HI   = 9'h006;
  localparam logic [ADDR_W-1:0] OFS_OUT_LO   = 9'h01C;
  localparam logic [ADDR_W-1:0] OFS_OUT_HI   = 9'h01E;
  localparam logic [ADDR_W-1:0] OFS_OEN_LO   = 9'h020;
  localparam logic [ADDR_W-1:0] OFS_OEN_HI   = 9'h022;
  localparam logic [ADDR_W-1:0] OFS_PULL_ON  = 9'h1E0;
  localparam logic [ADDR_W-1:0] OFS_PULL_DIR = 9'h1E2;

  // bit of the high output register that carries the first packed enable
  localparam int PACK_OE_LSB = 8;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_DIR_LO,
    SEL_DIR_HI,
    SEL_PIN_LO,
    SEL_PIN_HI,
    SEL_OUT_LO,
    SEL_OUT_HI,
    SEL_OEN_LO,
    SEL_OEN_HI,
    SEL_PULL_ON,
    SEL_PULL_DIR
  } reg_sel_e;

  // Map an offset to a register, honouring which registers the variant has.
  function automatic reg_sel_e decode_reg(logic [ADDR_W-1:0] a, int num_pins, bit sep_oe);
    reg_sel_e s;
    s = SEL_NONE;
    case (a)
      OFS_DIR_LO:   s = SEL_DIR_LO;
      OFS_DIR_HI:   s = SEL_DIR_HI;
      OFS_PIN_LO:   s = SEL_PIN_LO;
      OFS_PIN_HI:   s = SEL_PIN_HI;
      OFS_OUT_LO:   s = SEL_OUT_LO;
      OFS_OUT_HI:   s = (num_pins > 48) ? SEL_OUT_HI : SEL_NONE;
      OFS_OEN_LO:   s = sep_oe ? SEL_OEN_LO : SEL_NONE;
      OFS_OEN_HI:   s = (sep_oe && num_pins > 48) ? SEL_OEN_HI : SEL_NONE;
      OFS_PULL_ON:  s = (num_pins >= 50) ? SEL_PULL_ON : SEL_NONE;
      OFS_PULL_DIR: s = (num_pins >= 50) ? SEL_PULL_DIR : SEL_NONE;
      default:      s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_bus_port.sv
module gpio_bus_port
  import gpio_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  output logic              wr_en,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic take;

  // a pending response that is not consumed blocks the next request
  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;
  assign wr_en     = take && req_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (take) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? '0 : rd_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/gpio_reg_core.sv
module gpio_reg_core
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 50,
  parameter bit SEP_OE   = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  reg_sel_e            sel,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [BIDIR_N-1:0]  pin_sync,
  output logic [DATA_W-1:0]   rd_data,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [PULL_N-1:0]   pull_en,
  output logic [PULL_N-1:0]   pull_up
);

  localparam int UP       = NUM_PINS - BIDIR_N;
  localparam bit HAS_PULL = (NUM_PINS >= 50);

  logic [BIDIR_N-1:0] dir_q, dir_nxt;
  logic [BIDIR_N-1:0] dat_q, dat_nxt;
  logic [UP-1:0]      up_q, up_nxt;
  logic [UP-1:0]      oen_q, oen_nxt;
  logic [BIDIR_N-1:0] pin_view;
  logic [1:0][DATA_W-1:0] out_img;
  logic [1:0][DATA_W-1:0] oen_img;
  logic [UP-1:0]      up_oe;

  // bidirectional pins: direction and output latch
  always_comb begin
    dir_nxt = dir_q;
    dat_nxt = dat_q;
    for (int i = 0; i < BIDIR_N; i++) begin
      if (wr_en && sel == ((i < 16) ? SEL_DIR_LO : SEL_DIR_HI)) dir_nxt[i] = wdata[i % 16];
      if (wr_en && sel == ((i < 16) ? SEL_PIN_LO : SEL_PIN_HI)) dat_nxt[i] = wdata[i % 16];
    end
  end

  // output-only pins: data and enables, layout chosen by SEP_OE
  always_comb begin
    up_nxt  = up_q;
    oen_nxt = oen_q;
    for (int j = 0; j < UP; j++) begin
      if (wr_en && sel == ((j < 16) ? SEL_OUT_LO : SEL_OUT_HI)) up_nxt[j] = wdata[j % 16];
      if (SEP_OE) begin
        if (wr_en && sel == ((j < 16) ? SEL_OEN_LO : SEL_OEN_HI)) oen_nxt[j] = wdata[j % 16];
      end else if (j >= 16) begin
        if (wr_en && sel == SEL_OUT_HI) oen_nxt[j] = wdata[PACK_OE_LSB + j - 16];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      dat_q <= '0;
      up_q  <= '0;
      oen_q <= '0;
    end else begin
      dir_q <= dir_nxt;
      dat_q <= dat_nxt;
      up_q  <= up_nxt;
      oen_q <= oen_nxt;
    end
  end

  generate
    if (HAS_PULL) begin : g_pull
      logic [PULL_N-1:0] on_q, updn_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          on_q   <= '0;
          updn_q <= '0;
        end else if (wr_en) begin
          if (sel == SEL_PULL_ON)  on_q   <= wdata[PULL_N-1:0];
          if (sel == SEL_PULL_DIR) updn_q <= wdata[PULL_N-1:0];
        end
      end
      assign pull_en = on_q;
      assign pull_up = updn_q;
    end else begin : g_no_pull
      assign pull_en = '0;
      assign pull_up = '0;
    end
  endgenerate

  // register images of the output-only pins
  always_comb begin
    out_img = '0;
    oen_img = '0;
    for (int j = 0; j < UP; j++) begin
      out_img[j / 16][j % 16] = up_q[j];
      if (SEP_OE) begin
        oen_img[j / 16][j % 16] = oen_q[j];
        up_oe[j] = oen_q[j];
      end else begin
        if (j >= 16) out_img[1][PACK_OE_LSB + j - 16] = oen_q[j];
        up_oe[j] = (j < 16) ? 1'b1 : oen_q[j];
      end
    end
  end

  assign pin_view = (dir_q & dat_q) | (~dir_q & pin_sync);

  always_comb begin
    case (sel)
      SEL_DIR_LO:   rd_data = dir_q[15:0];
      SEL_DIR_HI:   rd_data = dir_q[31:16];
      SEL_PIN_LO:   rd_data = pin_view[15:0];
      SEL_PIN_HI:   rd_data = pin_view[31:16];
      SEL_OUT_LO:   rd_data = out_img[0];
      SEL_OUT_HI:   rd_data = out_img[1];
      SEL_OEN_LO:   rd_data = oen_img[0];
      SEL_OEN_HI:   rd_data = oen_img[1];
      SEL_PULL_ON:  rd_data = {1'b0, pull_en};
      SEL_PULL_DIR: rd_data = {1'b0, pull_up};
      default:      rd_data = '0;
    endcase
  end

  assign pad_out = {up_q, dat_q};
  assign pad_oe  = {up_oe, dir_q};

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS    = 50,
  parameter bit SEP_OE      = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [8:0]          req_addr,
  input  logic [15:0]         req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [15:0]         rsp_rdata,
  input  logic [31:0]         pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [14:0]         pull_en,
  output logic [14:0]         pull_up
);

  reg_sel_e           sel;
  logic               wr_en;
  logic [DATA_W-1:0]  rd_data;
  logic [BIDIR_N-1:0] pin_sync;

  assign sel = decode_reg(req_addr, NUM_PINS, SEP_OE);

  gpio_in_sync #(.W(BIDIR_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pin_sync)
  );

  gpio_bus_port u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .wr_en     (wr_en),
    .rd_data   (rd_data),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata)
  );

  gpio_reg_core #(.NUM_PINS(NUM_PINS), .SEP_OE(SEP_OE)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .sel      (sel),
    .wdata    (req_wdata),
    .pin_sync (pin_sync),
    .rd_data  (rd_data),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .pull_en  (pull_en),
    .pull_up  (pull_up)
  );

endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk #(
  parameter int NUM_PINS = 50
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic                req_write,
  input logic                rsp_valid,
  input logic                rsp_ready,
  input logic [15:0]         rsp_rdata,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [14:0]         pull_en,
  input logic [14:0]         pull_up
);

  a_r9_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  a_r9_rsp_held: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  a_r9_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  a_r2_dir_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pad_oe[31:0]) |-> $past(req_valid && req_ready && req_write));

  a_r7_pull_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(pull_en) || !$stable(pull_up)) |-> $past(req_valid && req_ready && req_write));

  for (genvar i = 0; i < 32; i++) begin : g_pin
    a_r10_no_glitch: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pad_oe[i]) |-> $stable(pad_out[i]));
  end

endmodule

bind gpio_port_regs gpio_port_regs_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .pull_en   (pull_en),
  .pull_up   (pull_up)
);

// File: tb/gpio_port_regs_bench.sv
module gpio_port_regs_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [8:0]  req_addr  = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_ready = 1'b1;
  logic [31:0] pad_in    = '0;

  logic        req_ready_a, rsp_valid_a, req_ready_b, rsp_valid_b;
  logic [15:0] rsp_rdata_a, rsp_rdata_b;
  logic [49:0] pad_out_a, pad_oe_a;
  logic [35:0] pad_out_b, pad_oe_b;
  logic [14:0] pull_en_a, pull_up_a, pull_en_b, pull_up_b;

  gpio_port_regs #(.NUM_PINS(50), .SEP_OE(1'b0)) u_gpio_port_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready_a),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid_a), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata_a),
    .pad_in(pad_in), .pad_out(pad_out_a), .pad_oe(pad_oe_a),
    .pull_en(pull_en_a), .pull_up(pull_up_a));

  gpio_port_regs #(.NUM_PINS(36), .SEP_OE(1'b1)) u_gpio_port_regs_sep (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready_b),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid_b), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata_b),
    .pad_in(pad_in), .pad_out(pad_out_b), .pad_oe(pad_oe_b),
    .pull_en(pull_en_b), .pull_up(pull_up_b));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model of both builds: index 0 = 50 pins packed, 1 = 36 pins separate
  int          cfg_n   [2] = '{50, 36};
  bit          cfg_sep [2] = '{1'b0, 1'b1};
  logic [31:0] m_dir [2];
  logic [31:0] m_dat [2];
  logic [17:0] m_up  [2];
  logic [17:0] m_oen [2];
  logic [14:0] m_on  [2];
  logic [14:0] m_ud  [2];

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int c = 0; c < 2; c++) begin
      m_dir[c] = '0; m_dat[c] = '0; m_up[c] = '0;
      m_oen[c] = '0; m_on[c] = '0; m_ud[c] = '0;
    end
  endfunction

  function automatic logic [17:0] up_mask(int c);
    return (18'h1 << (cfg_n[c] - 32)) - 18'h1;
  endfunction

  function automatic void model_write(int c, logic [8:0] a, logic [15:0] d);
    logic [17:0] um;
    um = up_mask(c);
    case (a)
      9'h000: m_dir[c][15:0]  = d;
      9'h002: m_dir[c][31:16] = d;
      9'h004: m_dat[c][15:0]  = d;
      9'h006: m_dat[c][31:16] = d;
      9'h01C: m_up[c][15:0]   = d & um[15:0];
      9'h01E: if (cfg_n[c] > 48) begin
                m_up[c][17:16] = d[1:0];
                if (!cfg_sep[c]) m_oen[c][17:16] = d[9:8];
              end
      9'h020: if (cfg_sep[c]) m_oen[c][15:0] = d & um[15:0];
      9'h022: if (cfg_sep[c] && cfg_n[c] > 48) m_oen[c][17:16] = d[1:0];
      9'h1E0: if (cfg_n[c] == 50) m_on[c] = d[14:0];
      9'h1E2: if (cfg_n[c] == 50) m_ud[c] = d[14:0];
      default: ;
    endcase
  endfunction

  function automatic logic [15:0] model_read(int c, logic [8:0] a);
    logic [31:0] pv;
    pv = (m_dir[c] & m_dat[c]) | (~m_dir[c] & pad_in);
    case (a)
      9'h000: return m_dir[c][15:0];
      9'h002: return m_dir[c][31:16];
      9'h004: return pv[15:0];
      9'h006: return pv[31:16];
      9'h01C: return m_up[c][15:0];
      9'h01E: return (cfg_n[c] > 48) ?
                {6'b0, (cfg_sep[c] ? 2'b00 : m_oen[c][17:16]), 6'b0, m_up[c][17:16]} : 16'h0;
      9'h020: return cfg_sep[c] ? m_oen[c][15:0] : 16'h0;
      9'h022: return (cfg_sep[c] && cfg_n[c] > 48) ? {14'b0, m_oen[c][17:16]} : 16'h0;
      9'h1E0: return (cfg_n[c] == 50) ? {1'b0, m_on[c]} : 16'h0;
      9'h1E2: return (cfg_n[c] == 50) ? {1'b0, m_ud[c]} : 16'h0;
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [63:0] exp_oe(int c);
    logic [63:0] v;
    v = '0;
    v[31:0] = m_dir[c];
    for (int j = 0; j < cfg_n[c] - 32; j++)
      v[32+j] = (cfg_sep[c] || j >= 16) ? m_oen[c][j] : 1'b1;
    return v;
  endfunction

  function automatic logic [63:0] exp_out(int c);
    logic [63:0] v;
    v = '0;
    v[31:0] = m_dat[c];
    for (int j = 0; j < cfg_n[c] - 32; j++) v[32+j] = m_up[c][j];
    return v;
  endfunction

  function automatic string tag_of(logic [8:0] a);
    case (a)
      9'h000, 9'h002: return "R2";
      9'h004, 9'h006: return "R3";
      9'h01C:         return "R4";
      9'h01E:         return "R5";
      9'h020, 9'h022: return "R6";
      9'h1E0, 9'h1E2: return "R7";
      default:        return "R8";
    endcase
  endfunction

  task automatic check_pads(string req);
    check({req, " pad_oe A"},  {14'b0, pad_oe_a},  exp_oe(0));
    check({req, " pad_out A"}, {14'b0, pad_out_a}, exp_out(0));
    check({req, " pad_oe B"},  {28'b0, pad_oe_b},  exp_oe(1));
    check({req, " pad_out B"}, {28'b0, pad_out_b}, exp_out(1));
    check({req, " pull A"}, {34'b0, pull_en_a, pull_up_a}, {34'b0, m_on[0], m_ud[0]});
    check({req, " pull B"}, {34'b0, pull_en_b, pull_up_b}, {34'b0, m_on[1], m_ud[1]});
  endtask

  // one bus transaction on both builds; the model follows after acceptance
  task automatic bus_op(bit wr, logic [8:0] a, logic [15:0] d);
    logic [15:0] ea, eb;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready_a) @(negedge clk);
    ea = wr ? 16'h0 : model_read(0, a);
    eb = wr ? 16'h0 : model_read(1, a);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 rsp_valid", {62'b0, rsp_valid_a, rsp_valid_b}, 64'h3);
    check({tag_of(a), " read A"}, {48'b0, rsp_rdata_a}, {48'b0, ea});
    check({tag_of(a), " read B"}, {48'b0, rsp_rdata_b}, {48'b0, eb});
    if (wr) begin
      model_write(0, a, d);
      model_write(1, a, d);
    end
    check_pads(wr ? tag_of(a) : "R8");
  endtask

  task automatic set_pads(logic [31:0] v);
    @(negedge clk);
    pad_in = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  logic [8:0] addr_pool [12] = '{9'h000, 9'h002, 9'h004, 9'h006, 9'h01C, 9'h01E,
                                  9'h020, 9'h022, 9'h1E0, 9'h1E2, 9'h008, 9'h024};

  initial begin
    void'($urandom(32'd1977));
    model_reset();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state on every mapped and unmapped location
    check_pads("R1");
    for (int k = 0; k < 12; k++) bus_op(1'b0, addr_pool[k], 16'h0);

    // R2 direction
    bus_op(1'b1, 9'h000, 16'hA5A5);
    bus_op(1'b1, 9'h002, 16'h0F0F);
    bus_op(1'b0, 9'h000, 16'h0);

    // R10 data first, direction second on pin 1 (input under 0xA5A5)
    bus_op(1'b1, 9'h004, 16'h0002);
    bus_op(1'b1, 9'h000, 16'hA5A7);
    check("R10 pin1 drives prepared level", {63'b0, pad_out_a[1] & pad_oe_a[1]}, 64'h1);

    // R3 mixed view of inputs and outputs
    set_pads(32'h3C3C_5AA5);
    bus_op(1'b0, 9'h004, 16'h0);
    bus_op(1'b0, 9'h006, 16'h0);
    set_pads(32'hC3C3_A55A);
    bus_op(1'b0, 9'h004, 16'h0);

    // R4 / R8 low output register, partly populated on the small build
    bus_op(1'b1, 9'h01C, 16'hFFFF);
    bus_op(1'b0, 9'h01C, 16'h0);
    // R5 packed enables and high data
    bus_op(1'b1, 9'h01E, 16'hFFFF);
    bus_op(1'b0, 9'h01E, 16'h0);
    check("R5 pins 48-49 enabled", {62'b0, pad_oe_a[49:48]}, 64'h3);
    // R6 separate enables
    bus_op(1'b1, 9'h020, 16'hFFFF);
    bus_op(1'b0, 9'h020, 16'h0);
    check("R6 pins 32-35 enabled", {60'b0, pad_oe_b[35:32]}, 64'hF);
    bus_op(1'b1, 9'h020, 16'h0005);
    // R7 pull control, bit 15 ignored
    bus_op(1'b1, 9'h1E0, 16'hFFFF);
    bus_op(1'b1, 9'h1E2, 16'h9234);
    bus_op(1'b0, 9'h1E0, 16'h0);
    bus_op(1'b0, 9'h1E2, 16'h0);
    // R8 holes and odd offsets
    bus_op(1'b1, 9'h008, 16'hFFFF);
    bus_op(1'b1, 9'h005, 16'hFFFF);
    bus_op(1'b1, 9'h1E4, 16'hFFFF);
    bus_op(1'b0, 9'h005, 16'h0);

    // R9 back-pressure: a held response blocks a pending write
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 9'h000;
    @(posedge clk);
    @(negedge clk);
    req_write = 1'b1; req_addr = 9'h1E0; req_wdata = 16'h0001;
    check("R9 ready low while held", {63'b0, req_ready_a}, 64'h0);
    repeat (3) @(negedge clk);
    check("R9 response held", {47'b0, rsp_valid_a, rsp_rdata_a}, {47'b0, 1'b1, m_dir[0][15:0]});
    check("R9 blocked write had no effect", {49'b0, pull_en_a}, {49'b0, m_on[0]});
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    model_write(0, 9'h1E0, 16'h0001);
    model_write(1, 9'h1E0, 16'h0001);
    check("R9 write response", {47'b0, rsp_valid_a, rsp_rdata_a}, {47'b0, 1'b1, 16'h0});
    check_pads("R7");

    // random mix against the model
    for (int n = 0; n < 400; n++) begin
      logic [8:0] a;
      a = addr_pool[$urandom_range(0, 11)];
      if ($urandom_range(0, 9) == 0) set_pads($urandom);
      bus_op($urandom_range(0, 1) == 1, a, 16'($urandom));
    end

    // R1 again: reset mid-run returns everything to zero
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
    check_pads("R1");

    finish_run();
  end

endmodule